// File: doc/BRIEF.md
# Static memory access phase sequencer

This block runs one access at a time to an asynchronous external static memory (SRAM, ROM or NOR-type parts) on behalf of an internal master. The master pulses a request with an address, a direction, write data and a mode choice. The block then walks the external bus through an address setup phase, an optional address hold phase and a data phase. It drives chip select, output enable, write enable, an address-valid strobe and a read-capture strobe. When the data phase ends it raises a one-cycle acknowledge. On reads, the captured word appears on the read-data output at the same time.

A 16-bit timing word sets the length of each phase. Software loads it through a simple write port. In the non-multiplexed mode the hold phase is skipped and reads get two extra data cycles. In the multiplexed mode all three phases run. The memory can pull an active-low wait line to stretch the data phase while it is busy. The block synchronises that line before use.

Top module: `smem_phase_seq`

## Requirements
- R1: After reset the timing word is 16'hFFFF. A read in non-multiplexed mode issued without loading the word therefore takes 16 setup cycles and 258 data cycles.
- R2: The address setup phase lasts setup field (bits 3:0) plus 1 cycles. mem_adv_n_o is low exactly during this phase.
- R3: The hold phase runs only in multiplexed mode (req_mux_i = 1) and lasts hold field (bits 7:4) plus 1 cycles. A hold code of 0 acts as 1, giving 2 cycles. Outside multiplexed mode no hold cycle occurs.
- R4: The data phase lasts data field (bits 15:8) plus 1 cycles. A data code of 0 acts as 1. A read in non-multiplexed mode adds 2 more cycles.
- R5: mem_cs_n_o is low from the first setup cycle through the last data cycle and high when idle. mem_oe_n_o is low only in data cycles of reads. mem_we_n_o is low only in data cycles of writes.
- R6: mem_wait_n_i passes through two flops. While the synchronised value is low during the data phase, the data phase does not advance.
- R7: On reads, mem_cap_o is high in the final data cycle only. In the next cycle ack_o pulses for one cycle, and rdata_o holds mem_rdata_i as sampled in that final cycle. Writes also acknowledge but never raise mem_cap_o.
- R8: A request is accepted only while busy_o is low. A request made while busy is ignored.
- R9: Phase lengths and mode are fixed when a request is accepted. A timing-word write during an access affects only later accesses.
- R10: mem_addr_o and mem_wdata_o keep the accepted request's values for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load the timing word |
| cfg_wdata_i | input | 16 | New timing word: data [15:8], hold [7:4], setup [3:0] |
| req_i | input | 1 | Request pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mux_i | input | 1 | 1 = multiplexed mode with hold phase |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| busy_o | output | 1 | Access in progress |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Last captured read data |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_wait_n_i | input | 1 | Memory wait, active low, asynchronous |
| mem_cap_o | output | 1 | Read-data capture strobe |

## Verification
Some properties are checked on every cycle. Output enable and write enable are never low together. No strobe appears outside chip select. The data counter stays frozen while wait is active. The acknowledge is a single cycle. The address stays stable through an access. Only the bench's scenarios can show the exact lengths of each phase. Those scenarios cover the reset timing, reserved zero codes, the extra read cycles, wait stretching through the synchroniser delay, ignored requests and a timing-word write during an access. The bench checks these by comparing every output against a behavioural model on each clock.

// File: rtl/smem_pkg.sv
package smem_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_HOLD  = 2'd2,
      PH_DATA  = 2'd3
   } phase_e;
endpackage

// File: rtl/smem_wait_sync.sv
module smem_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_n_i,
   output logic wait_act_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("smem_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '1;
      else        stg_q <= {stg_q[STAGES-2:0], wait_n_i};
   end

   assign wait_act_o = ~stg_q[STAGES-1];
endmodule

// File: rtl/smem_len_calc.sv
module smem_len_calc #(
   parameter int SET_W    = 4,
   parameter int HLD_W    = 4,
   parameter int DAT_W    = 8,
   parameter int CFG_W    = 16,
   parameter int RD_EXTRA = 2,
   parameter int LEN_W    = 10
) (
   input  logic [CFG_W-1:0] timing_i,
   input  logic             mux_i,
   input  logic             wr_i,
   output logic [LEN_W-1:0] setup_len_o,
   output logic [LEN_W-1:0] hold_len_o,
   output logic [LEN_W-1:0] data_len_o
);
   localparam int SET_LSB = 0;
   localparam int HLD_LSB = SET_W;
   localparam int DAT_LSB = SET_W + HLD_W;

   logic [SET_W-1:0] set_f;
   logic [HLD_W-1:0] hld_f, hld_eff;
   logic [DAT_W-1:0] dat_f, dat_eff;

   always_comb begin
      set_f   = timing_i[SET_LSB +: SET_W];
      hld_f   = timing_i[HLD_LSB +: HLD_W];
      dat_f   = timing_i[DAT_LSB +: DAT_W];
      hld_eff = (hld_f == '0) ? HLD_W'(1) : hld_f;
      dat_eff = (dat_f == '0) ? DAT_W'(1) : dat_f;
      setup_len_o = LEN_W'(set_f) + LEN_W'(1);
      hold_len_o  = LEN_W'(hld_eff) + LEN_W'(1);
      data_len_o  = LEN_W'(dat_eff) + LEN_W'(1)
                  + ((!mux_i && !wr_i) ? LEN_W'(RD_EXTRA) : LEN_W'(0));
   end
endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
   import smem_pkg::*;
#(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mux_i,
   input  logic             wr_i,
   input  logic [LEN_W-1:0] setup_len_i,
   input  logic [LEN_W-1:0] hold_len_i,
   input  logic [LEN_W-1:0] data_len_i,
   input  logic             wait_act_i,
   output phase_e           phase_o,
   output logic             wr_o,
   output logic             last_o,
   output logic             done_o
);
   phase_e           ph_q;
   logic [LEN_W-1:0] cnt_q, set_q, hld_q, dat_q;
   logic             mux_q, wr_q, done_q;
   logic             phase_end;

   always_comb begin
      unique case (ph_q)
         PH_SETUP: phase_end = (cnt_q == set_q - LEN_W'(1));
         PH_HOLD:  phase_end = (cnt_q == hld_q - LEN_W'(1));
         PH_DATA:  phase_end = (cnt_q == dat_q - LEN_W'(1)) && !wait_act_i;
         default:  phase_end = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         set_q  <= '0;
         hld_q  <= '0;
         dat_q  <= '0;
         mux_q  <= 1'b0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (start_i) begin
               ph_q  <= PH_SETUP;
               cnt_q <= '0;
               set_q <= setup_len_i;
               hld_q <= hold_len_i;
               dat_q <= data_len_i;
               mux_q <= mux_i;
               wr_q  <= wr_i;
            end
            PH_SETUP: if (phase_end) begin
               cnt_q <= '0;
               ph_q  <= mux_q ? PH_HOLD : PH_DATA;
            end else cnt_q <= cnt_q + LEN_W'(1);
            PH_HOLD: if (phase_end) begin
               cnt_q <= '0;
               ph_q  <= PH_DATA;
            end else cnt_q <= cnt_q + LEN_W'(1);
            PH_DATA: if (phase_end) begin
               cnt_q  <= '0;
               ph_q   <= PH_IDLE;
               done_q <= 1'b1;
            end else if (!wait_act_i) cnt_q <= cnt_q + LEN_W'(1);
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = ph_q;
   assign wr_o    = wr_q;
   assign last_o  = (ph_q == PH_DATA) && phase_end;
   assign done_o  = done_q;

   // R6
   wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DATA && wait_act_i) |=> (ph_q == PH_DATA && $stable(cnt_q)));
   // R3
   hold_only_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_HOLD) |-> mux_q);
endmodule

// File: rtl/smem_phase_seq.sv
module smem_phase_seq
   import smem_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int SET_W       = 4,
   parameter int HLD_W       = 4,
   parameter int DAT_W       = 8,
   parameter int CFG_W       = 16,
   parameter int RD_EXTRA    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic             req_i,
   input  logic             req_write_i,
   input  logic             req_mux_i,
   input  logic [AW-1:0]    req_addr_i,
   input  logic [DW-1:0]    req_wdata_i,
   output logic             busy_o,
   output logic             ack_o,
   output logic [DW-1:0]    rdata_o,
   output logic [AW-1:0]    mem_addr_o,
   output logic [DW-1:0]    mem_wdata_o,
   input  logic [DW-1:0]    mem_rdata_i,
   output logic             mem_cs_n_o,
   output logic             mem_adv_n_o,
   output logic             mem_oe_n_o,
   output logic             mem_we_n_o,
   input  logic             mem_wait_n_i,
   output logic             mem_cap_o
);
   localparam int LEN_W = DAT_W + 2;

   generate
      if (CFG_W != SET_W + HLD_W + DAT_W) begin : g_bad_cfg
         $error("smem_phase_seq: CFG_W must equal the sum of the field widths");
      end
      if (RD_EXTRA < 0 || RD_EXTRA > 2) begin : g_bad_extra
         $error("smem_phase_seq: RD_EXTRA must be 0..2");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [LEN_W-1:0] setup_len, hold_len, data_len;
   logic             wait_act, accept, last, wr_cur, done;
   phase_e           phase;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q, rdata_q;

   assign accept = req_i && (phase == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '1;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (cfg_we_i) cfg_q <= cfg_wdata_i;
         if (accept) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
         end
         if (mem_cap_o) rdata_q <= mem_rdata_i;
      end
   end

   smem_wait_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .wait_n_i(mem_wait_n_i), .wait_act_o(wait_act));

   smem_len_calc #(.SET_W(SET_W), .HLD_W(HLD_W), .DAT_W(DAT_W), .CFG_W(CFG_W),
                   .RD_EXTRA(RD_EXTRA), .LEN_W(LEN_W)) len_i (
      .timing_i(cfg_q), .mux_i(req_mux_i), .wr_i(req_write_i),
      .setup_len_o(setup_len), .hold_len_o(hold_len), .data_len_o(data_len));

   smem_phase_fsm #(.LEN_W(LEN_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .mux_i(req_mux_i),
      .wr_i(req_write_i), .setup_len_i(setup_len), .hold_len_i(hold_len),
      .data_len_i(data_len), .wait_act_i(wait_act), .phase_o(phase),
      .wr_o(wr_cur), .last_o(last), .done_o(done));

   assign busy_o      = (phase != PH_IDLE);
   assign ack_o       = done;
   assign rdata_o     = rdata_q;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign mem_cs_n_o  = (phase == PH_IDLE);
   assign mem_adv_n_o = (phase != PH_SETUP);
   assign mem_oe_n_o  = !((phase == PH_DATA) && !wr_cur);
   assign mem_we_n_o  = !((phase == PH_DATA) && wr_cur);
   assign mem_cap_o   = last && !wr_cur;

   // R5
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n_o && !mem_we_n_o));
   // R5
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n_o || !mem_we_n_o || !mem_adv_n_o) |-> !mem_cs_n_o);
   // R7
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && busy_o) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o)));
   // R8
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last) |=> busy_o);
endmodule

// File: tb/smem_phase_seq_tb.sv
module smem_phase_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [15:0] cfg_wdata_i = '0;
   logic        req_i = 1'b0, req_write_i = 1'b0, req_mux_i = 1'b0;
   logic [15:0] req_addr_i = '0, req_wdata_i = '0;
   logic        busy_o, ack_o;
   logic [15:0] rdata_o, mem_addr_o, mem_wdata_o;
   logic [15:0] mem_rdata_i = 16'h1234;
   logic        mem_cs_n_o, mem_adv_n_o, mem_oe_n_o, mem_we_n_o, mem_cap_o;
   logic        mem_wait_n_i = 1'b1;

   always #10 clk = ~clk;

   smem_phase_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
      .req_i(req_i), .req_write_i(req_write_i), .req_mux_i(req_mux_i),
      .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
      .ack_o(ack_o), .rdata_o(rdata_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_cs_n_o(mem_cs_n_o), .mem_adv_n_o(mem_adv_n_o),
      .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
      .mem_wait_n_i(mem_wait_n_i), .mem_cap_o(mem_cap_o));

   int    n_cmp = 0, n_bad = 0;
   string scen = "R1";

   // behavioural reference: phase number, cycles left in the phase
   int          m_ph = 0, m_rem = 0, m_hold = 0, m_data = 0;
   bit          m_ws0 = 1, m_ws1 = 1, m_mux = 0, m_wr = 0, m_ack = 0;
   logic [15:0] m_cfg = 16'hFFFF, m_addr = '0, m_wdata = '0, m_rdata = '0;

   always @(negedge clk) mem_rdata_i <= mem_rdata_i + 16'h0101;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_rem = 0; m_ws0 = 1; m_ws1 = 1; m_ack = 0;
         m_cfg = 16'hFFFF; m_addr = '0; m_wdata = '0; m_rdata = '0; m_wr = 0;
      end else begin
         bit wact;
         wact  = !m_ws1;
         m_ws1 = m_ws0;
         m_ws0 = mem_wait_n_i;
         m_ack = 0;
         case (m_ph)
            0: if (req_i) begin
               int a, h, d;
               a = m_cfg[3:0]; h = m_cfg[7:4]; d = m_cfg[15:8];
               if (h == 0) h = 1;
               if (d == 0) d = 1;
               m_wr = req_write_i; m_mux = req_mux_i;
               m_addr = req_addr_i; m_wdata = req_wdata_i;
               m_hold = h + 1;
               m_data = d + 1 + ((!req_mux_i && !req_write_i) ? 2 : 0);
               m_rem = a + 1; m_ph = 1;
            end
            1: begin
               m_rem--;
               if (m_rem == 0) begin
                  if (m_mux) begin m_ph = 2; m_rem = m_hold; end
                  else begin m_ph = 3; m_rem = m_data; end
               end
            end
            2: begin
               m_rem--;
               if (m_rem == 0) begin m_ph = 3; m_rem = m_data; end
            end
            default: if (!wact) begin
               if (m_rem == 1) begin
                  m_ph = 0; m_ack = 1;
                  if (!m_wr) m_rdata = mem_rdata_i;
               end else m_rem--;
            end
         endcase
         if (cfg_we_i) m_cfg = cfg_wdata_i;
      end
   end

   task automatic chk1(string req, string nm, logic [15:0] act, logic [15:0] exp,
                       inout bit bad);
      if (act !== exp) begin
         $display("FAIL %s (scenario %s) %s: actual %h expected %h at %0t",
                  req, scen, nm, act, exp, $time);
         bad = 1;
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         bit bad;
         bit e_cap;
         bad = 0;
         e_cap = (m_ph == 3) && (m_rem == 1) && m_ws1 && !m_wr;
         n_cmp++;
         chk1("R8",  "busy",  {15'd0, busy_o},      {15'd0, m_ph != 0}, bad);
         chk1("R5",  "cs_n",  {15'd0, mem_cs_n_o},  {15'd0, m_ph == 0}, bad);
         chk1("R2",  "adv_n", {15'd0, mem_adv_n_o}, {15'd0, m_ph != 1}, bad);
         chk1("R5",  "oe_n",  {15'd0, mem_oe_n_o},  {15'd0, !(m_ph == 3 && !m_wr)}, bad);
         chk1("R5",  "we_n",  {15'd0, mem_we_n_o},  {15'd0, !(m_ph == 3 && m_wr)}, bad);
         chk1("R7",  "cap",   {15'd0, mem_cap_o},   {15'd0, e_cap}, bad);
         chk1("R7",  "ack",   {15'd0, ack_o},       {15'd0, m_ack}, bad);
         chk1("R7",  "rdata", rdata_o,              m_rdata, bad);
         chk1("R10", "addr",  mem_addr_o,           m_addr, bad);
         chk1("R10", "wdata", mem_wdata_o,          m_wdata, bad);
         if (bad) n_bad++;
      end
   end

   task automatic load_cfg(logic [15:0] v);
      @(negedge clk); cfg_we_i = 1'b1; cfg_wdata_i = v;
      @(negedge clk); cfg_we_i = 1'b0;
   endtask

   task automatic access(bit wr, bit mux, logic [15:0] a, logic [15:0] d);
      @(negedge clk);
      req_i = 1'b1; req_write_i = wr; req_mux_i = mux;
      req_addr_i = a; req_wdata_i = d;
      @(negedge clk);
      req_i = 1'b0;
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog (scenario %s): actual hung expected done", scen);
      n_bad++;
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      n_cmp++;
      if (busy_o !== 1'b0 || mem_cs_n_o !== 1'b1 || ack_o !== 1'b0) begin
         $display("FAIL R5 reset idle: actual busy=%b cs_n=%b expected 0/1",
                  busy_o, mem_cs_n_o);
         n_bad++;
      end
      // R1: default slowest timing, non-mux read
      scen = "R1"; access(1'b0, 1'b0, 16'hA001, 16'h0);
      // R2 / R4: setup 3, data 1+1+2 extra read cycles
      scen = "R4"; load_cfg(16'h0132);
      access(1'b0, 1'b0, 16'hA002, 16'h0);
      scen = "R5"; access(1'b1, 1'b0, 16'hA003, 16'hBEEF);
      // R3: multiplexed with hold of 4
      scen = "R3"; access(1'b0, 1'b1, 16'hA004, 16'h0);
      access(1'b1, 1'b1, 16'hA005, 16'hCAFE);
      // R3 / R4 reserved zero codes
      scen = "R4"; load_cfg(16'h0000);
      access(1'b0, 1'b1, 16'hA006, 16'h0);
      access(1'b0, 1'b0, 16'hA007, 16'h0);
      // R6: wait stretches the data phase
      scen = "R6"; load_cfg(16'h0410);
      fork
         access(1'b0, 1'b1, 16'hA008, 16'h0);
         begin
            repeat (4) @(negedge clk); mem_wait_n_i = 1'b0;
            repeat (6) @(negedge clk); mem_wait_n_i = 1'b1;
         end
      join
      scen = "R6"; load_cfg(16'h0320);
      fork
         access(1'b1, 1'b1, 16'hA009, 16'h5555);
         begin
            repeat (2) @(negedge clk); mem_wait_n_i = 1'b0;
            repeat (9) @(negedge clk); mem_wait_n_i = 1'b1;
         end
      join
      // R8: a request while busy is ignored
      scen = "R8"; load_cfg(16'h0501);
      fork
         access(1'b0, 1'b0, 16'hA00A, 16'h0);
         begin
            repeat (3) @(negedge clk);
            req_i = 1'b1; req_write_i = 1'b1; req_addr_i = 16'hDEAD; req_wdata_i = 16'h7777;
            @(negedge clk); req_i = 1'b0;
         end
      join
      // R9: timing write mid-access applies to the next access only
      scen = "R9";
      fork
         access(1'b1, 1'b1, 16'hA00B, 16'h1111);
         begin repeat (2) @(negedge clk); load_cfg(16'h0203); end
      join
      access(1'b0, 1'b1, 16'hA00C, 16'h0);
      // R10: back-to-back different addresses
      scen = "R10"; access(1'b1, 1'b0, 16'h0F0F, 16'hF0F0);
      access(1'b0, 1'b0, 16'hFFFF, 16'h0);
      repeat (3) @(negedge clk);
      summary();
   end
endmodule